// File: doc/BRIEF.md
# MDIO Management Master Command Engine

This block is a clause 22 management master for PHY register access. It is controlled through one 32-bit word that holds both the command and the data. Software writes that word with the busy and enable bits set, a read/write select, a 5-bit PHY address, a 5-bit register address and, for a write, 16 data bits. The engine then sends the complete management frame on MDC/MDIO. When the frame ends it clears the busy bit. For a read it also leaves the 16 bits returned by the PHY in the low half of the same word.

MDC is produced from the system clock by a divider whose half-period is a parameter. The master changes MDIO after the falling edge of MDC and samples read data at the rising edge. During a read it releases the line from the first turnaround bit to the last data bit. While a frame is in flight the command word is locked, and any write to it is dropped.

Top module: `mdio_cmd_engine`

## Requirements
- R1: While reset is asserted and after it is released, the readback word is all zeros, MDC is low and the MDIO output enable is low.
- R2: A write in which bit 31 (busy) and bit 30 (enable) are both set, issued while idle, starts a frame. Bit 31 then reads 1 for exactly 128*DIV_HALF clock cycles and reads 0 afterwards.
- R3: A write in which bit 31 or bit 30 is clear stores the fields but starts no frame: bit 31 stays 0 and MDC stays low.
- R4: MDC is low when idle. During a frame it starts low and toggles every DIV_HALF clock cycles, which gives 64 full periods. MDIO never changes while MDC is high.
- R5: The frame bits, one per MDC period and sent MSB first, are: 32 ones, start 01, opcode 01 when bit 27 is 0 (write) or 10 when bit 27 is 1 (read), PHY address from bits 25:21, register address from bits 20:16, turnaround 10 (write only), and data from bits 15:0 (write only).
- R6: The output enable is high for every bit of a write frame and for frame bits 0..45 of a read. It is low for frame bits 46..63 of a read (turnaround and data) and low when idle.
- R7: For a read, MDIO input is sampled on the rising MDC edge of each of the 16 data bits. The value is placed in bits 15:0, MSB first, in the cycle in which busy clears.
- R8: A write issued while busy reads 1 is ignored, including in the cycle in which the frame completes. The readback word does not change while busy.
- R9: The readback word has busy in bit 31, enable in 30, read in 27, PHY address in 25:21, register address in 20:16 and data in 15:0. Bits 29, 28 and 26 read as 0.
- R10: After a write frame completes, bits 15:0 still hold the written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the command word |
| reg_wdata | input | 32 | Command word to write |
| reg_rdata | output | 32 | Readback of status, fields and data |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The bench builds the engine with DIV_HALF = 2, so a frame takes 256 cycles. At that length, several complete read and write frames fit in a short run, and the bench can compare every MDC half-period and each of the 64 frame bits cycle by cycle. The small divider also lets the bench place a write exactly on the completion cycle. It also covers all-ones and all-zeros address fields and read data with only the MSB or only the LSB set.

// File: rtl/mdio_eng_pkg.sv
package mdio_eng_pkg;

  localparam int unsigned WORD_W     = 32;
  localparam int unsigned DATA_W     = 16;
  localparam int unsigned ADDR_W     = 5;
  localparam int unsigned PRE_BITS   = 32;
  localparam int unsigned HDR_BITS   = 32;
  localparam int unsigned FRAME_BITS = PRE_BITS + HDR_BITS;
  localparam int unsigned IDX_W      = $clog2(FRAME_BITS);
  localparam int unsigned TA_POS     = PRE_BITS + 14;
  localparam int unsigned DAT_POS    = PRE_BITS + 16;

  localparam int unsigned BUSY_B  = 31;
  localparam int unsigned EN_B    = 30;
  localparam int unsigned RD_B    = 27;
  localparam int unsigned PHY_LSB = 21;
  localparam int unsigned REG_LSB = 16;

  typedef struct packed {
    logic              en;
    logic              rd;
    logic [ADDR_W-1:0] phy;
    logic [ADDR_W-1:0] regad;
    logic [DATA_W-1:0] data;
  } cmd_t;

  function automatic cmd_t cmd_unpack(input logic [WORD_W-1:0] w);
    cmd_t c;
    c.en    = w[EN_B];
    c.rd    = w[RD_B];
    c.phy   = w[PHY_LSB +: ADDR_W];
    c.regad = w[REG_LSB +: ADDR_W];
    c.data  = w[DATA_W-1:0];
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] status_pack(input logic busy, input cmd_t c);
    logic [WORD_W-1:0] w;
    w                    = '0;
    w[BUSY_B]            = busy;
    w[EN_B]              = c.en;
    w[RD_B]              = c.rd;
    w[PHY_LSB +: ADDR_W] = c.phy;
    w[REG_LSB +: ADDR_W] = c.regad;
    w[DATA_W-1:0]        = c.data;
    return w;
  endfunction

  // Header after the preamble: start, opcode, addresses, turnaround, data.
  function automatic logic [HDR_BITS-1:0] header_word(input cmd_t c);
    logic [1:0] op;
    logic [1:0] ta;
    logic [DATA_W-1:0] d;
    op = c.rd ? 2'b10 : 2'b01;
    ta = c.rd ? 2'b11 : 2'b10;
    d  = c.rd ? '0 : c.data;
    return {2'b01, op, c.phy, c.regad, ta, d};
  endfunction

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int unsigned DIV_HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_evt,
  output logic fall_evt
);

  localparam int unsigned CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;
  logic          term;

  assign term = run && (cnt_q == CNT_LAST);

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (term) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc      = mdc_q;
  assign rise_evt = term && !mdc_q;
  assign fall_evt = term && mdc_q;

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_eng_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  cmd_t              cmd,
  input  logic              rise_evt,
  input  logic              fall_evt,
  input  logic              mdio_i,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              mdio_o,
  output logic              mdio_oe
);

  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] IDX_HDR  = IDX_W'(PRE_BITS);
  localparam logic [IDX_W-1:0] IDX_TA   = IDX_W'(TA_POS);
  localparam logic [IDX_W-1:0] IDX_DAT  = IDX_W'(DAT_POS);

  logic                busy_q, busy_d;
  logic                rd_q, rd_d;
  logic [IDX_W-1:0]    idx_q, idx_d;
  logic [HDR_BITS-1:0] sr_q, sr_d;
  logic [DATA_W-1:0]   cap_q, cap_d;
  logic                in_hdr, in_dat, in_rel;

  assign in_hdr = idx_q >= IDX_HDR;
  assign in_dat = idx_q >= IDX_DAT;
  assign in_rel = idx_q >= IDX_TA;
  assign done   = busy_q && fall_evt && (idx_q == IDX_LAST);

  always_comb begin
    busy_d = busy_q;
    rd_d   = rd_q;
    idx_d  = idx_q;
    sr_d   = sr_q;
    cap_d  = cap_q;
    if (start) begin
      busy_d = 1'b1;
      rd_d   = cmd.rd;
      idx_d  = '0;
      sr_d   = header_word(cmd);
    end else if (busy_q) begin
      if (rise_evt && rd_q && in_dat) begin
        cap_d = {cap_q[DATA_W-2:0], mdio_i};
      end
      if (fall_evt) begin
        if (idx_q == IDX_LAST) begin
          busy_d = 1'b0;
        end else begin
          idx_d = idx_q + IDX_W'(1);
        end
        if (in_hdr) begin
          sr_d = {sr_q[HDR_BITS-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      idx_q  <= '0;
      sr_q   <= '0;
      cap_q  <= '0;
    end else begin
      busy_q <= busy_d;
      rd_q   <= rd_d;
      idx_q  <= idx_d;
      sr_q   <= sr_d;
      cap_q  <= cap_d;
    end
  end

  assign busy    = busy_q;
  assign rd_data = cap_q;
  assign mdio_o  = (busy_q && in_hdr) ? sr_q[HDR_BITS-1] : 1'b1;
  assign mdio_oe = busy_q && !(rd_q && in_rel);

endmodule

// File: rtl/mdio_cmd_regs.sv
module mdio_cmd_regs
  import mdio_eng_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              busy,
  input  logic              done,
  input  logic [DATA_W-1:0] rd_data,
  output logic              start,
  output cmd_t              cmd,
  output logic [WORD_W-1:0] rdata
);

  cmd_t cmd_q, cmd_d;
  logic accept;
  logic unused_wbits;

  assign unused_wbits = ^{wdata[29:28], wdata[26]};
  assign accept       = wr && !busy;
  assign start        = accept && wdata[BUSY_B] && wdata[EN_B];

  always_comb begin
    cmd_d = cmd_q;
    if (accept) begin
      cmd_d = cmd_unpack(wdata);
    end else if (done && cmd_q.rd) begin
      cmd_d.data = rd_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
    end else begin
      cmd_q <= cmd_d;
    end
  end

  // The frame shifter loads from the incoming word on the start cycle.
  assign cmd   = cmd_unpack(wdata);
  assign rdata = status_pack(busy, cmd_q);

endmodule

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine
  import mdio_eng_pkg::*;
#(
  parameter int unsigned DIV_HALF = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);

  logic              start;
  cmd_t              cmd;
  logic              busy;
  logic              done;
  logic              rise_evt;
  logic              fall_evt;
  logic [DATA_W-1:0] rd_data;

  mdio_cmd_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (reg_wr),
    .wdata   (reg_wdata),
    .busy    (busy),
    .done    (done),
    .rd_data (rd_data),
    .start   (start),
    .cmd     (cmd),
    .rdata   (reg_rdata)
  );

  mdio_clk_div #(.DIV_HALF(DIV_HALF)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy),
    .mdc      (mdc),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  mdio_frame_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .cmd      (cmd),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt),
    .mdio_i   (mdio_i),
    .busy     (busy),
    .done     (done),
    .rd_data  (rd_data),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe)
  );

endmodule

// File: rtl/mdio_cmd_engine_chk.sv
module mdio_cmd_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe
);

  logic busy;
  assign busy = reg_rdata[31];

  a_r4_mdc_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  a_r6_oe_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);

  a_r4_mdio_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |-> $stable(mdio_o));

  a_r8_word_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(reg_rdata));

  a_r2_start_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_wr && reg_wdata[31] && reg_wdata[30]));

  a_r3_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !busy && !(reg_wdata[31] && reg_wdata[30])) |=> !busy);

  a_r9_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[29:28] == 2'b00) && !reg_rdata[26]);

endmodule

bind mdio_cmd_engine mdio_cmd_engine_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .mdc       (mdc),
  .mdio_o    (mdio_o),
  .mdio_oe   (mdio_oe)
);

// File: tb/mdio_cmd_engine_bench.sv
module mdio_cmd_engine_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 2;
  localparam int FRAME_CYC  = 128 * DIV;

  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        mdc;
  logic        mdio_o;
  logic        mdio_oe;
  logic        mdio_i;

  int n_tests;
  int n_fail;
  bit finished;

  mdio_cmd_engine #(.DIV_HALF(DIV)) u_mdio_cmd_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .mdio_i    (mdio_i)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // Reference model state
  bit          m_busy;
  int          m_k;
  logic [31:0] m_ctrl;
  logic [63:0] m_frame;
  bit          m_rd;
  logic [15:0] m_cap;
  logic [15:0] phy_resp;

  function automatic logic [63:0] build_frame(input logic [31:0] w);
    logic [63:0] f;
    bit rd;
    rd = w[27];
    f  = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), w[25:21], w[20:16],
          (rd ? 2'b11 : 2'b10), (rd ? 16'h0000 : w[15:0])};
    return f;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_k = 0; m_ctrl = '0; m_rd = 0; m_cap = '0;
    end else if (m_busy) begin
      int kn;
      int bitn;
      kn   = m_k + 1;
      bitn = m_k / (2 * DIV);
      if ((kn % DIV) == 0 && ((kn / DIV) % 2) == 1 && m_rd && bitn >= 48)
        m_cap = {m_cap[14:0], mdio_i};
      m_k = kn;
      if (kn == FRAME_CYC) begin
        m_busy = 0;
        if (m_rd) m_ctrl[15:0] = m_cap;
      end
    end else if (reg_wr) begin
      m_ctrl = reg_wdata & 32'h4BFF_FFFF;
      if (reg_wdata[31] && reg_wdata[30]) begin
        m_busy  = 1;
        m_k     = 0;
        m_rd    = reg_wdata[27];
        m_frame = build_frame(reg_wdata);
      end
    end
  end

  // PHY model: drives response data bits during the data phase of reads.
  always @(negedge clk) begin
    int b;
    b = m_k / (2 * DIV);
    if (m_busy && m_rd && b >= 48) mdio_i <= phy_resp[63 - b];
    else mdio_i <= 1'b1;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int b;
      b = m_k / (2 * DIV);
      check("R2 busy", {31'd0, reg_rdata[31]}, {31'd0, m_busy});
      check("R9 word", reg_rdata, m_ctrl | (m_busy ? 32'h8000_0000 : 32'h0));
      if (m_busy) begin
        check("R4 mdc", {31'd0, mdc}, 32'((m_k / DIV) % 2));
        check("R6 oe", {31'd0, mdio_oe}, {31'd0, !(m_rd && b >= 46)});
        if (!(m_rd && b >= 46))
          check("R5 mdio", {31'd0, mdio_o}, {31'd0, m_frame[63 - b]});
      end else begin
        check("R4 mdc idle", {31'd0, mdc}, 32'd0);
        check("R6 oe idle", {31'd0, mdio_oe}, 32'd0);
      end
    end
  end

  task automatic wr_word(input logic [31:0] w);
    @(negedge clk);
    reg_wr    = 1'b1;
    reg_wdata = w;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic wait_idle();
    while (m_busy) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] cmd(input bit rd, input logic [4:0] phy,
                                      input logic [4:0] ra, input logic [15:0] d);
    return {1'b1, 1'b1, 2'b00, rd, 1'b0, phy, ra, d};
  endfunction

  initial begin
    n_tests = 0; n_fail = 0; finished = 0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_wdata = '0; phy_resp = 16'h0000;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 rdata", reg_rdata, 32'h0);
    check("R1 mdc", {31'd0, mdc}, 32'd0);
    check("R1 oe", {31'd0, mdio_oe}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rdata after release", reg_rdata, 32'h0);

    // Write frame, with an ignored write in the middle (R8)
    wr_word(cmd(0, 5'h11, 5'h0A, 16'hA5C3));
    repeat (40) @(negedge clk);
    wr_word(cmd(1, 5'h02, 5'h03, 16'h1234));
    check("R8 ignored write", reg_rdata, 32'hC000_0000 | (32'h11 << 21) | (32'h0A << 16) | 32'hA5C3);
    wait_idle();
    check("R10 data kept", {16'd0, reg_rdata[15:0]}, 32'h0000_A5C3);

    // Read frame
    phy_resp = 16'h3C96;
    wr_word(cmd(1, 5'h03, 5'h1F, 16'hFFFF));
    wait_idle();
    check("R7 read data", {16'd0, reg_rdata[15:0]}, 32'h0000_3C96);

    // No start without both bits (R3)
    wr_word(32'h8000_0000 | (32'h5 << 21));
    repeat (10) @(negedge clk);
    check("R3 busy only", reg_rdata, 32'h5 << 21);
    check("R3 mdc low", {31'd0, mdc}, 32'd0);
    wr_word(32'h4800_1234);
    repeat (10) @(negedge clk);
    check("R3 enable only", reg_rdata, 32'h4800_1234);

    // Boundary addresses and data
    phy_resp = 16'h8000;
    wr_word(cmd(1, 5'h1F, 5'h00, 16'h0000));
    wait_idle();
    check("R7 msb only", {16'd0, reg_rdata[15:0]}, 32'h0000_8000);
    phy_resp = 16'h0001;
    wr_word(cmd(1, 5'h00, 5'h1F, 16'h0000));
    wait_idle();
    check("R7 lsb only", {16'd0, reg_rdata[15:0]}, 32'h0000_0001);
    wr_word(cmd(0, 5'h00, 5'h00, 16'hFFFF));

    // Write landing exactly on the completion edge is ignored (R8)
    while (!(m_busy && m_k == FRAME_CYC - 1)) @(negedge clk);
    reg_wr = 1'b1;
    reg_wdata = cmd(1, 5'h07, 5'h07, 16'h0000);
    @(negedge clk);
    reg_wr = 1'b0;
    check("R8 completion edge", reg_rdata, 32'h4000_FFFF);
    check("R2 cleared", {31'd0, reg_rdata[31]}, 32'd0);
    wr_word(cmd(0, 5'h15, 5'h0A, 16'h5A5A));
    wait_idle();
    check("R10 second write", {16'd0, reg_rdata[15:0]}, 32'h0000_5A5A);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule